// File: doc/BRIEF.md
# Bang-Bang Costas Carrier Recovery Loop

This block locks a local numerically controlled oscillator to the suppressed carrier of a sampled BPSK stream. Each valid signed sample is multiplied by a cosine and a sine taken from a 16-bit phase accumulator. Each of the two mixer products passes through a first-order leaky integrator, which removes the double-frequency term. The two filter outputs are I and Q.

The phase detector uses the product I*Q. Only the sign of that product, summed over a group of samples, is kept. The sign moves an up/down counter one step, and the counter value is the NCO frequency word. The counter has no proportional path and stops at programmable bounds. A lock flag compares the number of up-steps with the number of down-steps over a fixed window of counter updates. The loop may settle at either 0 or pi, because both are valid BPSK positions.

Top module: `costas_bb_loop`

## Requirements
- R1: While rst_n is low at a clock edge (synchronous reset), freq_word loads freq_init, i_out and q_out clear to 0, locked clears to 0, the phase accumulator clears to 0 and the sample and window counters restart.
- R2: The phase accumulator advances by freq_word on every valid sample. The sample taken with index n after reset (n from 0) is mixed with the table entries addressed by the top 6 bits of the phase. The cosine is +127 at address 0 and 0 at address 16. The sine is 0 at address 0, +127 at address 16, and -127 at address 48.
- R3: On each valid sample, i_out becomes y + ((x - y) >>> 4), saturated to 16 signed bits. Here y is the previous i_out and x is smp_in times the cosine entry. q_out follows the same rule, using the sine entry.
- R4: The loop sums i_out*q_out over 8 valid samples, using the register values present at each of those samples. On the 8th sample it makes one counter decision. A negative sum steps freq_word up by one. A zero or positive sum steps it down by one.
- R5: freq_word never passes freq_max when stepping up or freq_min when stepping down. At a bound it holds its value.
- R6: A cycle with smp_vld low changes none of freq_word, i_out, q_out or locked, whatever smp_in carries.
- R7: Every 64 counter decisions, locked is set if the up and down counts in that window differ by at most 4, and cleared otherwise. Between window ends it holds.
- R8: freq_word changes by at most one LSB, and only on the valid sample that completes a group of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | smp_in carries a sample this cycle |
| smp_in | input | 8 | Signed input sample |
| freq_init | input | 16 | Frequency word loaded at reset |
| freq_min | input | 16 | Lower bound of the frequency word |
| freq_max | input | 16 | Upper bound of the frequency word |
| i_out | output | 16 | Filtered in-phase arm, signed |
| q_out | output | 16 | Filtered quadrature arm, signed |
| freq_word | output | 16 | Current NCO phase increment |
| locked | output | 1 | Up/down steps balanced in the last window |

## Verification
The assertions assume that freq_min <= freq_init <= freq_max. They also assume that the three bound inputs change only while rst_n is low, since the bounds check compares against their present values. The stimulus respects both conditions. It changes the bounds only inside its reset task, in the same cycle that reset goes low, and it holds them until the next reset.

To make each counter decision predictable, the stimulus pins or nearly pins the frequency word at a quarter turn per sample. It then aligns a four-sample input pattern to the sample index, which fixes the sign of I*Q.

// File: rtl/costas_bb_loop.sv
module costas_bb_loop #(
  parameter int SMP_W    = 8,
  parameter int PH_W     = 16,
  parameter int FILT_W   = 16,
  parameter int LPF_SH   = 4,
  parameter int UPD_N    = 8,
  parameter int WIN_LEN  = 64,
  parameter int LOCK_TOL = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_vld,
  input  logic signed [SMP_W-1:0]  smp_in,
  input  logic [PH_W-1:0]          freq_init,
  input  logic [PH_W-1:0]          freq_min,
  input  logic [PH_W-1:0]          freq_max,
  output logic signed [FILT_W-1:0] i_out,
  output logic signed [FILT_W-1:0] q_out,
  output logic [PH_W-1:0]          freq_word,
  output logic                     locked
);
  localparam int LUT_AW = 6;
  localparam int LUT_W  = 8;
  localparam int MIX_W  = SMP_W + LUT_W;
  localparam int PROD_W = 2 * FILT_W;
  localparam int CNT_W  = $clog2(UPD_N);
  localparam int ACC_W  = PROD_W + CNT_W + 1;
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int DIF_W  = WIN_W + 2;
  localparam logic [LUT_AW-1:0] QTR = LUT_AW'(2 ** (LUT_AW - 2));
  localparam logic signed [DIF_W-1:0] TOL_P = DIF_W'(LOCK_TOL);
  localparam logic signed [DIF_W-1:0] TOL_N = -TOL_P;

  function automatic logic signed [LUT_W-1:0] quarter(input logic [4:0] k);
    case (k)
      5'd0:  quarter = 8'sd0;   5'd1:  quarter = 8'sd12;  5'd2:  quarter = 8'sd25;
      5'd3:  quarter = 8'sd37;  5'd4:  quarter = 8'sd49;  5'd5:  quarter = 8'sd60;
      5'd6:  quarter = 8'sd71;  5'd7:  quarter = 8'sd81;  5'd8:  quarter = 8'sd90;
      5'd9:  quarter = 8'sd98;  5'd10: quarter = 8'sd106; 5'd11: quarter = 8'sd112;
      5'd12: quarter = 8'sd117; 5'd13: quarter = 8'sd122; 5'd14: quarter = 8'sd125;
      5'd15: quarter = 8'sd126; default: quarter = 8'sd127;
    endcase
  endfunction

  function automatic logic signed [LUT_W-1:0] wave(input logic [LUT_AW-1:0] a);
    logic signed [LUT_W-1:0] mag;
    mag = a[4] ? quarter(5'd16 - {1'b0, a[3:0]}) : quarter({1'b0, a[3:0]});
    wave = a[5] ? -mag : mag;
  endfunction

  function automatic logic signed [FILT_W-1:0] leak(input logic signed [FILT_W-1:0] y,
                                                    input logic signed [MIX_W-1:0] x);
    logic signed [FILT_W+1:0] d, s;
    d = (FILT_W+2)'(x) - (FILT_W+2)'(y);
    s = (FILT_W+2)'(y) + (d >>> LPF_SH);
    if (s[FILT_W+1:FILT_W-1] != {3{s[FILT_W+1]}})
      leak = s[FILT_W+1] ? {1'b1, {(FILT_W-1){1'b0}}} : {1'b0, {(FILT_W-1){1'b1}}};
    else
      leak = s[FILT_W-1:0];
  endfunction

  logic [PH_W-1:0]          phase;
  logic [LUT_AW-1:0]        addr;
  logic signed [LUT_W-1:0]  cos_v, sin_v;
  logic signed [MIX_W-1:0]  mix_i, mix_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc, acc_nx;
  logic [CNT_W-1:0]         smp_cnt;
  logic [WIN_W-1:0]         upd_cnt;
  logic signed [DIF_W-1:0]  diff, diff_nx;
  logic                     upd_fire, go_up, win_end;

  assign addr     = phase[PH_W-1 -: LUT_AW];
  assign cos_v    = wave(addr + QTR);
  assign sin_v    = wave(addr);
  assign mix_i    = smp_in * cos_v;
  assign mix_q    = smp_in * sin_v;
  assign prod     = i_out * q_out;
  assign acc_nx   = acc + ACC_W'(prod);
  assign upd_fire = smp_vld && (smp_cnt == CNT_W'(UPD_N - 1));
  assign go_up    = acc_nx[ACC_W-1];
  assign win_end  = (upd_cnt == WIN_W'(WIN_LEN - 1));
  assign diff_nx  = go_up ? diff + DIF_W'(1) : diff - DIF_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      i_out   <= '0;
      q_out   <= '0;
      acc     <= '0;
      smp_cnt <= '0;
    end else if (smp_vld) begin
      phase   <= phase + freq_word;
      i_out   <= leak(i_out, mix_i);
      q_out   <= leak(q_out, mix_q);
      acc     <= upd_fire ? '0 : acc_nx;
      smp_cnt <= upd_fire ? '0 : smp_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_word <= freq_init;
      upd_cnt   <= '0;
      diff      <= '0;
      locked    <= 1'b0;
    end else if (upd_fire) begin
      if (go_up && freq_word < freq_max)        freq_word <= freq_word + PH_W'(1);
      else if (!go_up && freq_word > freq_min)  freq_word <= freq_word - PH_W'(1);
      if (win_end) begin
        upd_cnt <= '0;
        diff    <= '0;
        locked  <= (diff_nx <= TOL_P) && (diff_nx >= TOL_N);
      end else begin
        upd_cnt <= upd_cnt + WIN_W'(1);
        diff    <= diff_nx;
      end
    end
  end

  p_freq_in_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freq_word >= freq_min && freq_word <= freq_max);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(freq_word) && $stable(i_out) && $stable(q_out) && $stable(locked));

  p_one_lsb_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> (freq_word == $past(freq_word)) || (freq_word == $past(freq_word) + PH_W'(1))
                 || (freq_word == $past(freq_word) - PH_W'(1)));

  p_freq_only_on_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> $stable(freq_word));

  p_lock_at_window_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_fire && win_end) |=> $stable(locked));
endmodule

// File: tb/costas_bb_loop_tb.sv
module costas_bb_loop_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [7:0] smp_in = '0;
  logic [15:0] freq_init = '0, freq_min = '0, freq_max = '0;
  logic signed [15:0] i_out, q_out;
  logic [15:0] freq_word;
  logic locked;
  int checks = 0, fails = 0, nsmp = 0;

  always #5 clk = ~clk;

  costas_bb_loop u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
    .freq_init(freq_init), .freq_min(freq_min), .freq_max(freq_max),
    .i_out(i_out), .q_out(q_out), .freq_word(freq_word), .locked(locked));

  // input sample, expected i_out with the frequency word pinned at 0 (R3)
  localparam logic [23:0] VEC [6] = '{
    {8'sd64,   16'sd508},
    {8'sd64,   16'sd984},
    {-8'sd100, 16'sd128},
    {8'sd0,    16'sd120},
    {8'sd127,  16'sd1120},
    {-8'sd128, 16'sd34}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] init, input logic [15:0] lo, input logic [15:0] hi);
    rst_n = 1'b0;
    smp_vld = 1'b0;
    freq_init = init; freq_min = lo; freq_max = hi;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    nsmp = 0;
  endtask

  task automatic push(input logic signed [7:0] v);
    smp_in = v; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    nsmp++;
  endtask

  task automatic idle(input logic signed [7:0] v);
    smp_in = v; smp_vld = 1'b0;
    @(negedge clk);
  endtask

  // up = 0: I and Q same sign (down step); up = 1: opposite signs (up step)
  task automatic pattern(input bit up, input int n);
    for (int k = 0; k < n; k++) begin
      int ph = nsmp % 4;
      logic signed [7:0] v;
      if (!up) v = (ph < 2) ? 8'sd64 : -8'sd64;
      else     v = (ph == 0 || ph == 3) ? 8'sd64 : -8'sd64;
      push(v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    do_reset(16'd1000, 16'd0, 16'hFFFF);
    check("R1 freq_word", freq_word, 1000);
    check("R1 i_out", i_out, 0);
    check("R1 q_out", q_out, 0);
    check("R1 locked", locked, 0);

    // R2/R3 table walk, NCO pinned at phase 0: cosine +127, sine 0
    do_reset(16'd0, 16'd0, 16'd0);
    for (int k = 0; k < 6; k++) begin
      push(VEC[k][23:16]);
      check("R3 i_out", i_out, int'($signed(VEC[k][15:0])));
      check("R2 q_out", q_out, 0);
    end
    // R6 an invalid sample leaves the filter untouched
    idle(8'sd127);
    check("R6 i_out hold", i_out, 34);

    // R4/R8 zero error counts as a down step, once per 8 samples
    do_reset(16'd1000, 16'd0, 16'hFFFF);
    repeat (7) push(8'sd0);
    check("R8 no step before 8th", freq_word, 1000);
    push(8'sd0);
    check("R4 down on zero", freq_word, 999);
    repeat (3) idle(8'sd100);
    check("R6 freq hold", freq_word, 999);
    check("R6 q hold", q_out, 0);
    repeat (8) push(8'sd0);
    check("R8 second step", freq_word, 998);

    // R4 up step then R5 ceiling
    do_reset(16'h4000, 16'h4000, 16'h4001);
    pattern(1'b1, 8);
    check("R4 up step", freq_word, 16'h4001);
    pattern(1'b1, 24);
    check("R5 hold at max", freq_word, 16'h4001);

    // R4 down step then R5 floor
    do_reset(16'h4001, 16'h4000, 16'h4001);
    pattern(1'b0, 8);
    check("R4 down step", freq_word, 16'h4000);
    pattern(1'b0, 24);
    check("R5 hold at min", freq_word, 16'h4000);

    // R7 balanced decisions set the flag, one-sided ones clear it
    do_reset(16'h4000, 16'h4000, 16'h4000);
    for (int b = 0; b < 24; b++) pattern(b[0], 64);
    check("R7 lock set", locked, 1);
    pattern(1'b0, 1024);
    check("R7 lock cleared", locked, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule